// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block produces one active-low interrupt line for each side of a shared dual-port word memory. The two highest word addresses work as mailboxes: the next-to-last word belongs to port A, the last word to port B. When one port writes into the other port's mailbox, the owner's interrupt goes low. The owner acknowledges by accessing its own mailbox with both the enable and the output enable low, which raises the line again. Both mailbox words stay ordinary read/write storage in the memory array; this block only watches the port controls and does not hold any data.

Each port presents an active-low enable, an active-low output enable, an active-low write strobe, a word address and a busy indication from the address arbiter. An access that the arbiter has marked busy leaves both flags alone. The flags are registered on a single clock with a synchronous active-high reset, so a set or a clear shows on the interrupt pin one clock after the access is presented.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While reset is high, and on the first clock after reset, both a_irq_n and b_irq_n are 1 (no interrupt pending).
- R2: A port B write (b_en_n=0, b_we_n=0, b_busy=0) to address 2^ADDR_W-2 drives a_irq_n to 0 on the next clock.
- R3: A port A write (a_en_n=0, a_we_n=0, a_busy=0) to address 2^ADDR_W-1 drives b_irq_n to 0 on the next clock.
- R4: A port A access with a_en_n=0, a_oe_n=0, a_busy=0 to address 2^ADDR_W-2 drives a_irq_n to 1 on the next clock, whatever the value of a_we_n.
- R5: A port B access with b_en_n=0, b_oe_n=0, b_busy=0 to address 2^ADDR_W-1 drives b_irq_n to 1 on the next clock, whatever the value of b_we_n.
- R6: An access on a port whose busy input is 1 neither sets nor clears any interrupt.
- R7: When a set and a clear of the same interrupt are presented in the same clock, the interrupt becomes pending (line at 0).
- R8: A port's own write to its own mailbox with its output enable high, an access with the enable high, and any access to another address change neither interrupt.
- R9: With no set or clear presented, each interrupt line keeps its value from clock to clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_en_n | input | 1 | Port A enable, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_we_n | input | 1 | Port A write strobe, active low |
| a_busy | input | 1 | Port A access blocked by the arbiter, active high |
| a_addr | input | ADDR_W | Port A word address |
| b_en_n | input | 1 | Port B enable, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_we_n | input | 1 | Port B write strobe, active low |
| b_busy | input | 1 | Port B access blocked by the arbiter, active high |
| b_addr | input | ADDR_W | Port B word address |
| a_irq_n | output | 1 | Port A interrupt, active low |
| b_irq_n | output | 1 | Port B interrupt, active low |

## Verification
The bench builds the controller with ADDR_W=3, so the memory has eight words and the mailboxes sit at addresses 6 and 7. With that width every combination of the four control bits and the address on both ports, 16384 joint input patterns, is applied in four passes with different orderings, so each pattern meets the flags in varied states and the set-against-clear collisions, busy blocking and near-miss addresses are all reached. Directed sequences before the sweep pin down reset, each set and clear path, and the set-wins rule with expected values stated per step.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Control bits of one port as seen at the pins
    typedef struct packed {
        logic en_n;
        logic oe_n;
        logic we_n;
        logic busy;
    } port_ctl_t;

    // Index of each side in per-port arrays
    localparam int unsigned SIDE_A = 0;
    localparam int unsigned SIDE_B = 1;
    localparam int unsigned NUM_SIDES = 2;

    // An unblocked write strobe with the port enabled
    function automatic logic is_write(input port_ctl_t c);
        return !c.en_n && !c.we_n && !c.busy;
    endfunction

    // An unblocked access with outputs enabled (write strobe ignored)
    function automatic logic is_ack(input port_ctl_t c);
        return !c.en_n && !c.oe_n && !c.busy;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned OWN_BOX = 0,
    parameter int unsigned PEER_BOX = 1
) (
    input  port_ctl_t          ctl,
    input  logic [ADDR_W-1:0]  addr,
    output logic               peer_set,
    output logic               own_clr
);
    localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(OWN_BOX);
    localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(PEER_BOX);

    always_comb begin
        peer_set = is_write(ctl) && (addr == PEER_A);
        own_clr  = is_ack(ctl)   && (addr == OWN_A);
    end
endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic irq_n
);
    logic pending_q;

    always_ff @(posedge clk) begin
        if (rst)
            pending_q <= 1'b0;
        else if (set_req)
            pending_q <= 1'b1;
        else if (clr_req)
            pending_q <= 1'b0;
    end

    assign irq_n = ~pending_q;
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_en_n,
    input  logic              a_oe_n,
    input  logic              a_we_n,
    input  logic              a_busy,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_en_n,
    input  logic              b_oe_n,
    input  logic              b_we_n,
    input  logic              b_busy,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              a_irq_n,
    output logic              b_irq_n
);
    localparam int unsigned TOP_WORD = (1 << ADDR_W) - 1;

    port_ctl_t         ctl  [NUM_SIDES];
    logic [ADDR_W-1:0] addr [NUM_SIDES];
    logic              set_peer [NUM_SIDES];
    logic              clr_own  [NUM_SIDES];
    logic              irq_line [NUM_SIDES];

    always_comb begin
        ctl[SIDE_A]  = '{en_n: a_en_n, oe_n: a_oe_n, we_n: a_we_n, busy: a_busy};
        ctl[SIDE_B]  = '{en_n: b_en_n, oe_n: b_oe_n, we_n: b_we_n, busy: b_busy};
        addr[SIDE_A] = a_addr;
        addr[SIDE_B] = b_addr;
    end

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        // Side A owns the word below the top, side B the top word
        localparam int unsigned OWN  = TOP_WORD - 1 + g;
        localparam int unsigned PEER = TOP_WORD - g;

        mbx_port_decode #(
            .ADDR_W   (ADDR_W),
            .OWN_BOX  (OWN),
            .PEER_BOX (PEER)
        ) u_dec (
            .ctl      (ctl[g]),
            .addr     (addr[g]),
            .peer_set (set_peer[g]),
            .own_clr  (clr_own[g])
        );

        mbx_irq_flag u_flag (
            .clk     (clk),
            .rst     (rst),
            .set_req (set_peer[NUM_SIDES-1-g]),
            .clr_req (clr_own[g]),
            .irq_n   (irq_line[g])
        );
    end

    assign a_irq_n = irq_line[SIDE_A];
    assign b_irq_n = irq_line[SIDE_B];
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              a_en_n,
    input logic              a_oe_n,
    input logic              a_we_n,
    input logic              a_busy,
    input logic [ADDR_W-1:0] a_addr,
    input logic              b_en_n,
    input logic              b_oe_n,
    input logic              b_we_n,
    input logic              b_busy,
    input logic [ADDR_W-1:0] b_addr,
    input logic              a_irq_n,
    input logic              b_irq_n
);
    localparam logic [ADDR_W-1:0] BOX_A = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] BOX_B = {ADDR_W{1'b1}};

    logic set_a, set_b, clr_a, clr_b;
    assign set_a = !b_en_n && !b_we_n && !b_busy && (b_addr == BOX_A);
    assign set_b = !a_en_n && !a_we_n && !a_busy && (a_addr == BOX_B);
    assign clr_a = !a_en_n && !a_oe_n && !a_busy && (a_addr == BOX_A);
    assign clr_b = !b_en_n && !b_oe_n && !b_busy && (b_addr == BOX_B);

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (a_irq_n && b_irq_n));

    // R2
    a_set_chk: assert property (@(posedge clk) disable iff (rst) set_a |=> !a_irq_n);

    // R3
    b_set_chk: assert property (@(posedge clk) disable iff (rst) set_b |=> !b_irq_n);

    // R4
    a_clr_chk: assert property (@(posedge clk) disable iff (rst) (clr_a && !set_a) |=> a_irq_n);

    // R5
    b_clr_chk: assert property (@(posedge clk) disable iff (rst) (clr_b && !set_b) |=> b_irq_n);

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (a_busy && b_busy) |=> ($stable(a_irq_n) && $stable(b_irq_n)));

    // R9
    a_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_a && !clr_a) |=> $stable(a_irq_n));

    // R9
    b_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_b && !clr_b) |=> $stable(b_irq_n));
endmodule

bind mbx_irq_ctrl mbx_irq_chk #(.ADDR_W(ADDR_W)) u_irq_chk (
    .clk     (clk),
    .rst     (rst),
    .a_en_n  (a_en_n),
    .a_oe_n  (a_oe_n),
    .a_we_n  (a_we_n),
    .a_busy  (a_busy),
    .a_addr  (a_addr),
    .b_en_n  (b_en_n),
    .b_oe_n  (b_oe_n),
    .b_we_n  (b_we_n),
    .b_busy  (b_busy),
    .b_addr  (b_addr),
    .a_irq_n (a_irq_n),
    .b_irq_n (b_irq_n)
);

// File: tb/tb_mbx_irq_ctrl.sv
`timescale 1ns/1ps
module tb_mbx_irq_ctrl;
    localparam int unsigned AW = 3;
    localparam int unsigned MB_A = 6;
    localparam int unsigned MB_B = 7;
    localparam int unsigned WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst;
    logic          a_en_n, a_oe_n, a_we_n, a_busy;
    logic [AW-1:0] a_addr;
    logic          b_en_n, b_oe_n, b_we_n, b_busy;
    logic [AW-1:0] b_addr;
    logic          a_irq_n, b_irq_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic exp_a, exp_b;   // expected line levels

    always #2 clk = ~clk;

    mbx_irq_ctrl #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst),
        .a_en_n(a_en_n), .a_oe_n(a_oe_n), .a_we_n(a_we_n), .a_busy(a_busy), .a_addr(a_addr),
        .b_en_n(b_en_n), .b_oe_n(b_oe_n), .b_we_n(b_we_n), .b_busy(b_busy), .b_addr(b_addr),
        .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    // ports: {addr, busy, we_n, oe_n, en_n}
    task automatic drive_a(input logic [6:0] v);
        {a_addr, a_busy, a_we_n, a_oe_n, a_en_n} = v;
    endtask
    task automatic drive_b(input logic [6:0] v);
        {b_addr, b_busy, b_we_n, b_oe_n, b_en_n} = v;
    endtask

    function automatic logic [6:0] pv(input int unsigned ad, input logic bz,
                                      input logic we, input logic oe, input logic en);
        return {ad[AW-1:0], bz, we, oe, en};
    endfunction

    localparam logic [6:0] IDLE = {3'd0, 1'b0, 1'b1, 1'b1, 1'b1};

    task automatic check(input string req, input logic ea, input logic eb);
        checks = checks + 1;
        if (a_irq_n !== ea || b_irq_n !== eb) begin
            errors = errors + 1;
            $display("FAIL %s: actual a_irq_n=%b b_irq_n=%b expected a_irq_n=%b b_irq_n=%b",
                     req, a_irq_n, b_irq_n, ea, eb);
        end
    endtask

    // one clock: drive at negedge, check at next negedge
    task automatic step(input logic [6:0] va, input logic [6:0] vb,
                        input string req, input logic ea, input logic eb);
        drive_a(va);
        drive_b(vb);
        @(negedge clk);
        check(req, ea, eb);
    endtask

    initial begin
        rst = 1'b1;
        drive_a(IDLE);
        drive_b(IDLE);
        @(negedge clk);
        @(negedge clk);
        check("R1", 1'b1, 1'b1);
        rst = 1'b0;
        step(IDLE, IDLE, "R1", 1'b1, 1'b1);

        // R2: B writes A's mailbox
        step(IDLE, pv(MB_A, 0, 0, 1, 0), "R2", 1'b0, 1'b1);
        step(IDLE, IDLE, "R9", 1'b0, 1'b1);
        // R3: A writes B's mailbox
        step(pv(MB_B, 0, 0, 1, 0), IDLE, "R3", 1'b0, 1'b0);
        // R8: own write to own mailbox with oe high, enable high, wrong address
        step(pv(MB_A, 0, 0, 1, 0), pv(MB_B, 0, 0, 1, 0), "R8", 1'b0, 1'b0);
        step(pv(MB_A, 0, 1, 0, 1), pv(MB_B, 0, 1, 0, 1), "R8", 1'b0, 1'b0);
        step(pv(5, 0, 1, 0, 0), pv(5, 0, 1, 0, 0), "R8", 1'b0, 1'b0);
        // R6: busy blocks clears
        step(pv(MB_A, 1, 1, 0, 0), pv(MB_B, 1, 1, 0, 0), "R6", 1'b0, 1'b0);
        // R4: A clears with a write strobe low (we ignored)
        step(pv(MB_A, 0, 0, 0, 0), IDLE, "R4", 1'b1, 1'b0);
        // R5: B clears with a read
        step(IDLE, pv(MB_B, 0, 1, 0, 0), "R5", 1'b1, 1'b1);
        // R6: busy blocks sets
        step(pv(MB_B, 1, 0, 1, 0), pv(MB_A, 1, 0, 1, 0), "R6", 1'b1, 1'b1);
        // R7: set and clear of A's flag together
        step(pv(MB_A, 0, 1, 0, 0), pv(MB_A, 0, 0, 1, 0), "R7", 1'b0, 1'b1);
        // R7: set and clear of B's flag together
        step(pv(MB_B, 0, 0, 1, 0), pv(MB_B, 0, 1, 0, 0), "R7", 1'b0, 1'b0);
        // R1: reset while both pending
        rst = 1'b1;
        step(IDLE, IDLE, "R1", 1'b1, 1'b1);
        rst = 1'b0;

        // Sweep of all joint patterns, four orderings, model tracked
        exp_a = 1'b1;
        exp_b = 1'b1;
        for (int pass = 0; pass < 4; pass++) begin
            for (int k = 0; k < 16384; k++) begin
                logic [13:0] idx;
                logic [6:0]  va, vb;
                logic        sa, sb, ca, cb;
                idx = 14'((k * 9973 + pass * 4099) & 16383);
                va = idx[6:0];
                vb = idx[13:7];
                // field order {addr, busy, we_n, oe_n, en_n}
                sa = !vb[0] && !vb[2] && !vb[3] && (vb[6:4] == MB_A);
                sb = !va[0] && !va[2] && !va[3] && (va[6:4] == MB_B);
                ca = !va[0] && !va[1] && !va[3] && (va[6:4] == MB_A);
                cb = !vb[0] && !vb[1] && !vb[3] && (vb[6:4] == MB_B);
                if (sa) exp_a = 1'b0; else if (ca) exp_a = 1'b1;
                if (sb) exp_b = 1'b0; else if (cb) exp_b = 1'b1;
                step(va, vb, (sa || sb) ? "R2/R3 sweep" : (ca || cb) ? "R4/R5 sweep" : "R9 sweep",
                     exp_a, exp_b);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule